// File: doc/BRIEF.md
# Task-Event UART Controller

This block is a byte-wide serial port run from a small word-addressed register file. Software turns the port on through a control register and then triggers one-shot tasks that arm reception, arm transmission or halt both directions. Completion is reported through sticky event registers that software polls or routes to an interrupt line, and clears by writing zero.

On the receive side, a sampler recovers 8N1 frames from the line. Completed bytes pass through a small buffer to a single data register. One byte is shown at a time, and each one raises its own ready event. On the transmit side, a byte written to the transmit data register is serialised only while transmission is armed and the shifter is idle. Any other write is dropped rather than queued. The bit time is a fixed number of clock cycles set by a parameter.

Top module: `uart_te_ctrl`

## Requirements
- R1: After reset the serial output is high, the interrupt output is low, and every register at offsets 0x0 to 0xB reads 0.
- R2: The port is on only while the control register at offset 0x0 holds exactly 4. While it is off, frames arriving on the line are discarded, the receive event stays 0 and the receive data register (offset 0x6) keeps reading 0.
- R3: Writing 1 to the receive-arm task (offset 0x1) while the port is on makes every valid frame set the receive event (offset 0x4) and show its byte at offset 0x6. A valid frame has a low start bit, eight data bits sent LSB first and a high stop bit, each lasting CLKS_PER_BIT clocks. Frames that arrive while the port is on but not armed are discarded.
- R4: An event register reads 1 while its event is pending. Writing 0 to it clears it. Writing any non-zero value leaves it unchanged.
- R5: Bytes received back to back are shown in arrival order, with exactly one receive event per byte. The next byte appears only after software has cleared the pending event.
- R6: Bytes waiting behind the shown one are held in a buffer of RX_DEPTH entries. A frame that completes while that buffer is full is dropped and sets bit 0 of the status register (offset 0xB). Writing 0 to the status register clears that bit.
- R7: The interrupt-enable register (offset 0x8) is written directly, is OR-ed with the data written to offset 0x9, and has the data written to offset 0xA cleared from it.
- R8: The interrupt output is high exactly when the receive event is pending with enable bit 2 set, or the transmit event is pending with enable bit 7 set.
- R9: After the transmit-arm task (offset 0x2, write 1), a byte written to offset 0x7 is sent as one 8N1 frame. The transmit event (offset 0x5) rises only after the stop bit has finished.
- R10: The halt task (offset 0x3, write 1) disarms both directions. A byte written to offset 0x7 while halted is neither sent nor kept. After a new transmit-arm task, only bytes written from then on are sent.
- R11: A byte written to offset 0x7 while a frame is still being shifted out is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every byte value through both the receiver and the transmitter. A sampler that is off by one bit, or a shifter that sends MSB first, would therefore fail on nearly all codes. It sends frames while the port is off, on but unarmed, and set to a control value other than 4. A gate that is too loose would then show those bytes. A burst larger than the buffer checks that the extra byte sets the overrun bit, and that the buffered bytes drain in order with one event each. A presenter that skipped or repeated entries would be caught here. Transmit writes made while halted or while busy are checked at the line and the transmit event, where a design that queued them would send an extra frame. The mid-stop-bit sample catches a transmit event raised too early.

// File: rtl/uart_te_pkg.sv
// Package: register offsets and the receiver state type shared by the
// task-event UART modules. Offsets are word indices on a 4-bit address.
package uart_te_pkg;
    localparam logic [3:0] OFS_ENABLE  = 4'h0;
    localparam logic [3:0] OFS_RXARM   = 4'h1;
    localparam logic [3:0] OFS_TXARM   = 4'h2;
    localparam logic [3:0] OFS_HALT    = 4'h3;
    localparam logic [3:0] OFS_EVRX    = 4'h4;
    localparam logic [3:0] OFS_EVTX    = 4'h5;
    localparam logic [3:0] OFS_RXDATA  = 4'h6;
    localparam logic [3:0] OFS_TXDATA  = 4'h7;
    localparam logic [3:0] OFS_IE      = 4'h8;
    localparam logic [3:0] OFS_IESET   = 4'h9;
    localparam logic [3:0] OFS_IECLR   = 4'hA;
    localparam logic [3:0] OFS_STATUS  = 4'hB;

    localparam logic [7:0] ENABLE_CODE = 8'd4;
    localparam int IE_BIT_RX = 2;
    localparam int IE_BIT_TX = 7;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_te_rx.sv
// Receive sampler: recovers 8N1 frames from an idle-high line.
// Assumes CLKS_PER_BIT >= 4. The line is synchronised with two flops, the
// start bit is confirmed at its middle, and each data bit and the stop bit
// are sampled one bit time apart. Frames with a low stop bit are dropped.
module uart_te_rx
    import uart_te_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       byte_vld,
    output logic [7:0] byte_o
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

    logic [1:0]    sync_q;
    rx_state_t     st_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          rxs;

    assign rxs = sync_q[1];

    // Two-flop synchroniser for the asynchronous line, reset to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // Frame state machine: start detect, data sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= RXS_IDLE;
            cnt_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            case (st_q)
                RXS_IDLE: begin
                    cnt_q <= '0;
                    if (!rxs) st_q <= RXS_START;
                end
                RXS_START: begin
                    if (cnt_q == HALF) begin
                        cnt_q <= '0;
                        bit_q <= '0;
                        st_q  <= rxs ? RXS_IDLE : RXS_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RXS_DATA: begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        sh_q  <= {rxs, sh_q[7:1]};
                        if (bit_q == 3'd7) st_q <= RXS_STOP;
                        else               bit_q <= bit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == LAST) begin
                        cnt_q    <= '0;
                        byte_vld <= rxs;
                        st_q     <= RXS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign byte_o = sh_q;
endmodule

// File: rtl/uart_te_tx.sv
// Transmit shifter: sends one 8N1 frame per load, LSB first.
// Assumes load is asserted only while busy is low. done pulses for one
// cycle in the cycle the stop bit ends. The line is high when idle.
module uart_te_tx #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       busy,
    output logic       done,
    output logic       tx_o
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam int FRAME_BITS = 10;

    logic [FRAME_BITS-1:0] sh_q;
    logic [CW-1:0]         cnt_q;
    logic [3:0]            nbit_q;

    // Frame shifter: loads start/data/stop and shifts once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            nbit_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                sh_q   <= {1'b1, data, 1'b0};
                cnt_q  <= '0;
                nbit_q <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
                    if (nbit_q == 4'(FRAME_BITS - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        nbit_q <= nbit_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign tx_o = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_te_fifo.sv
// Receive buffer: first-in first-out store of received bytes.
// Assumes DEPTH is a power of two, at least 2. A push while full is
// ignored; the parent reports it as an overrun.
module uart_te_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem_q [DEPTH];
    logic [AW:0]  wp_q, rp_q;

    assign empty = (wp_q == rp_q);
    assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign head  = mem_q[rp_q[AW-1:0]];

    // Pointer update: write on push when not full, read on pop when not empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push && !full) wp_q <= wp_q + 1'b1;
            if (pop && !empty) rp_q <= rp_q + 1'b1;
        end
    end

    // Storage: entries are written only; no reset is needed on the array.
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && !full && (wp_q[AW-1:0] == AW'(g)))
                    mem_q[g] <= push_data;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_te_ctrl.sv
// Task-event UART top: register file, tasks, sticky events, interrupt
// and the glue between the receive sampler, buffer and transmit shifter.
// Assumes a single-cycle write strobe and a combinational read of reg_addr.
module uart_te_ctrl
    import uart_te_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int RX_DEPTH     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rx_i,
    output logic       tx_o,
    output logic       irq_o
);
    logic [7:0] en_q, ie_q, rxd_q;
    logic       rx_run_q, tx_run_q, ev_rx, ev_tx, overrun;
    logic       uart_on;
    logic       rx_vld, rx_accept, fifo_pop, fifo_empty, fifo_full;
    logic [7:0] rx_byte, fifo_head;
    logic       txd_wr, tx_load, tx_busy, tx_done, tx_line;
    logic       wr_en, wr_rxarm, wr_txarm, wr_halt, wr_evrx, wr_evtx;
    logic       wr_ie, wr_ieset, wr_ieclr, wr_status;

    assign uart_on   = (en_q == ENABLE_CODE);
    assign wr_en     = reg_wr && (reg_addr == OFS_ENABLE);
    assign wr_rxarm  = reg_wr && (reg_addr == OFS_RXARM) && reg_wdata[0];
    assign wr_txarm  = reg_wr && (reg_addr == OFS_TXARM) && reg_wdata[0];
    assign wr_halt   = reg_wr && (reg_addr == OFS_HALT)  && reg_wdata[0];
    assign wr_evrx   = reg_wr && (reg_addr == OFS_EVRX)  && (reg_wdata == 8'd0);
    assign wr_evtx   = reg_wr && (reg_addr == OFS_EVTX)  && (reg_wdata == 8'd0);
    assign wr_ie     = reg_wr && (reg_addr == OFS_IE);
    assign wr_ieset  = reg_wr && (reg_addr == OFS_IESET);
    assign wr_ieclr  = reg_wr && (reg_addr == OFS_IECLR);
    assign wr_status = reg_wr && (reg_addr == OFS_STATUS) && (reg_wdata == 8'd0);
    assign txd_wr    = reg_wr && (reg_addr == OFS_TXDATA);

    assign rx_accept = rx_vld && uart_on && rx_run_q;
    assign fifo_pop  = uart_on && !ev_rx && !fifo_empty;
    assign tx_load   = txd_wr && uart_on && tx_run_q && !tx_busy;

    uart_te_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
        .byte_vld(rx_vld), .byte_o(rx_byte)
    );

    uart_te_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_accept), .push_data(rx_byte),
        .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full)
    );

    uart_te_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .data(reg_wdata),
        .busy(tx_busy), .done(tx_done), .tx_o(tx_line)
    );

    assign tx_o = tx_line;

    // Control register and the run flags set by tasks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            rx_run_q <= 1'b0;
            tx_run_q <= 1'b0;
        end else begin
            if (wr_en) en_q <= reg_wdata;
            if (wr_halt) begin
                rx_run_q <= 1'b0;
                tx_run_q <= 1'b0;
            end else begin
                if (wr_rxarm) rx_run_q <= 1'b1;
                if (wr_txarm) tx_run_q <= 1'b1;
            end
        end
    end

    // Sticky events: hardware sets, a write of zero clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_rx <= 1'b0;
            ev_tx <= 1'b0;
        end else begin
            if (fifo_pop)     ev_rx <= 1'b1;
            else if (wr_evrx) ev_rx <= 1'b0;
            if (tx_done)      ev_tx <= 1'b1;
            else if (wr_evtx) ev_tx <= 1'b0;
        end
    end

    // Presented receive byte, loaded from the buffer head on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n)        rxd_q <= '0;
        else if (fifo_pop) rxd_q <= fifo_head;
    end

    // Interrupt enables with direct, set and clear write paths.
    always_ff @(posedge clk) begin
        if (!rst_n)        ie_q <= '0;
        else if (wr_ie)    ie_q <= reg_wdata;
        else if (wr_ieset) ie_q <= ie_q | reg_wdata;
        else if (wr_ieclr) ie_q <= ie_q & ~reg_wdata;
    end

    // Overrun status: set when a frame finds the buffer full.
    always_ff @(posedge clk) begin
        if (!rst_n)                       overrun <= 1'b0;
        else if (rx_accept && fifo_full)  overrun <= 1'b1;
        else if (wr_status)               overrun <= 1'b0;
    end

    // Interrupt combine from pending events and their enables.
    assign irq_o = (ev_rx && ie_q[IE_BIT_RX]) || (ev_tx && ie_q[IE_BIT_TX]);

    // Read multiplexer over the register offsets.
    always_comb begin
        case (reg_addr)
            OFS_ENABLE: reg_rdata = en_q;
            OFS_EVRX:   reg_rdata = {7'd0, ev_rx};
            OFS_EVTX:   reg_rdata = {7'd0, ev_tx};
            OFS_RXDATA: reg_rdata = rxd_q;
            OFS_IE:     reg_rdata = ie_q;
            OFS_STATUS: reg_rdata = {7'd0, overrun};
            default:    reg_rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/uart_te_chk.sv
// Checker: temporal properties of the task-event UART, bound to the top.
module uart_te_chk (
    input logic clk,
    input logic rst_n,
    input logic uart_on,
    input logic ev_rx,
    input logic ev_tx,
    input logic irq,
    input logic tx_busy,
    input logic tx_line,
    input logic tx_run,
    input logic txd_wr,
    input logic rx_accept,
    input logic fifo_full,
    input logic overrun
);
    // R2: no receive event may appear while the port is off.
    p_rx_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_on |=> !$rose(ev_rx));

    // R8: the interrupt needs a pending event behind it.
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_rx || ev_tx));

    // R9: the line idles high whenever no frame is in flight.
    p_tx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    // R10: a data write while disarmed starts no frame.
    p_tx_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !tx_run && !tx_busy) |=> !tx_busy);

    // R6: a frame arriving at a full buffer raises overrun.
    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept && fifo_full) |=> overrun);
endmodule

bind uart_te_ctrl uart_te_chk u_chk (
    .clk(clk), .rst_n(rst_n), .uart_on(uart_on),
    .ev_rx(ev_rx), .ev_tx(ev_tx), .irq(irq_o),
    .tx_busy(tx_busy), .tx_line(tx_line), .tx_run(tx_run_q),
    .txd_wr(txd_wr), .rx_accept(rx_accept), .fifo_full(fifo_full),
    .overrun(overrun)
);

// File: tb/sim_uart_te_ctrl.sv
module sim_uart_te_ctrl;
    localparam int CPB   = 8;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h0;
    logic [7:0] reg_rdata;
    logic       rx_i = 1'b1;
    logic       tx_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_te_ctrl #(.CLKS_PER_BIT(CPB), .RX_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_i(rx_i), .tx_o(tx_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (CPB + 3) @(negedge clk);
    endtask

    // Decodes one frame from tx_o; ok=0 if no start bit within the window.
    task automatic get_tx(output logic [7:0] b, output bit ok, output int ev_mid);
        int n = 0;
        b = 8'h00; ok = 1'b0; ev_mid = 0;
        while (tx_o && n < 4 * CPB) begin
            @(negedge clk); n++;
        end
        if (tx_o) return;
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (CPB) @(negedge clk);
            b[i] = tx_o;
        end
        repeat (CPB) @(negedge clk);
        ok = tx_o;
        reg_addr = 4'h5;
        #1 ev_mid = int'(reg_rdata);
        repeat (CPB + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        logic [7:0] b;
        bit ok;
        int evm;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 tx idle", int'(tx_o), 1);
        check("R1 irq", int'(irq_o), 0);
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            check("R1 reg", v, 0);
        end

        // R2: off port ignores frames
        wr(4'h1, 8'h1);
        send_rx(8'h5A);
        rd(4'h6, v); check("R2 rxdata off", v, 0);
        rd(4'h4, v); check("R2 event off", v, 0);
        wr(4'h0, 8'h5);
        send_rx(8'h33);
        rd(4'h4, v); check("R2 code 5 not on", v, 0);
        // R3: on but not armed
        wr(4'h3, 8'h1);
        wr(4'h0, 8'h4);
        rd(4'h0, v); check("R2 enable reads", v, 4);
        send_rx(8'h77);
        rd(4'h4, v); check("R3 unarmed", v, 0);
        rd(4'h6, v); check("R3 unarmed data", v, 0);

        // R3: sweep every byte through the receiver, R4 clearing each time
        wr(4'h1, 8'h1);
        for (int k = 0; k < 256; k++) begin
            send_rx(8'(k));
            rd(4'h4, v); check("R3 event", v, 1);
            rd(4'h6, v); check("R3 data", v, k);
            if (k == 17) begin
                wr(4'h4, 8'h1);
                rd(4'h4, v); check("R4 nonzero no clear", v, 1);
            end
            wr(4'h4, 8'h0);
            rd(4'h4, v); check("R4 cleared", v, 0);
        end

        // R5/R6: burst of DEPTH+2 bytes without clearing
        for (int k = 0; k < DEPTH + 2; k++) send_rx(8'(8'hC0 + k));
        rd(4'hB, v); check("R6 overrun set", v, 1);
        for (int k = 0; k < DEPTH + 1; k++) begin
            rd(4'h4, v); check("R5 one event", v, 1);
            rd(4'h6, v); check("R5 order", v, 8'hC0 + k);
            wr(4'h4, 8'h0);
            repeat (2) @(negedge clk);
        end
        rd(4'h4, v); check("R6 dropped byte", v, 0);
        wr(4'hB, 8'h0);
        rd(4'hB, v); check("R6 overrun clear", v, 0);

        // R7: enable aliases
        wr(4'h9, 8'h04); rd(4'h8, v); check("R7 set", v, 8'h04);
        wr(4'hA, 8'h04); rd(4'h8, v); check("R7 clear", v, 0);
        wr(4'h9, 8'h80); wr(4'h9, 8'h04); rd(4'h8, v); check("R7 or", v, 8'h84);
        wr(4'h8, 8'h10); rd(4'h8, v); check("R7 direct", v, 8'h10);

        // R8: interrupt from receive event
        wr(4'h8, 8'h04);
        send_rx(8'h21);
        check("R8 rx irq", int'(irq_o), 1);
        wr(4'h4, 8'h0);
        check("R8 rx irq clear", int'(irq_o), 0);

        // R9: transmit sweep over every byte
        wr(4'h2, 8'h1);
        for (int k = 0; k < 256; k++) begin
            wr(4'h7, 8'(k));
            get_tx(b, ok, evm);
            check("R9 frame", int'(b), k);
            check("R9 stop", int'(ok), 1);
            if (k < 4) check("R9 event late", evm, 0);
            rd(4'h5, v); check("R9 event", v, 1);
            if (k == 1) check("R8 tx masked", int'(irq_o), 0);
            if (k == 2) begin
                wr(4'h9, 8'h80);
                check("R8 tx irq", int'(irq_o), 1);
                wr(4'hA, 8'h80);
            end
            wr(4'h5, 8'h0);
        end

        // R10: halted write is lost
        wr(4'h3, 8'h1);
        wr(4'h7, 8'hA5);
        get_tx(b, ok, evm);
        check("R10 no frame", int'(ok), 0);
        rd(4'h5, v); check("R10 no event", v, 0);
        wr(4'h2, 8'h1);
        wr(4'h7, 8'h3C);
        get_tx(b, ok, evm);
        check("R10 new byte only", int'(b), 8'h3C);
        get_tx(b, ok, evm);
        check("R10 no stale frame", int'(ok), 0);
        wr(4'h5, 8'h0);

        // R11: write while busy discarded
        wr(4'h7, 8'h11);
        wr(4'h7, 8'h22);
        get_tx(b, ok, evm);
        check("R11 first byte", int'(b), 8'h11);
        wr(4'h5, 8'h0);
        get_tx(b, ok, evm);
        check("R11 no second frame", int'(ok), 0);
        rd(4'h5, v); check("R11 no event", v, 0);

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule